// File: doc/BRIEF.md
# Half-Duplex Backplane Transceiver Controller

This block holds the logic side of a ten-lane half-duplex transceiver that sits between a local logic bus and a wired-OR backplane. Eight data lanes form two groups of four. Two auxiliary lanes carry a clock or data. A side path sends a parity bit out and brings a frame pulse back. Every bidirectional pin appears as a separate input, output and enable. Each backplane lane is driven only through a pull-low enable. A released line reads high through the external pull-up.

A small direction state machine decides whether the block is transmitting, receiving, or idle. It has three states: `DIR_OFF`, `DIR_TX` and `DIR_RX`. The machine reacts to four requests: `REQ_NONE`, `REQ_TX`, `REQ_RX` and `REQ_HOLD`. From `DIR_OFF` it moves to `DIR_TX` on `REQ_TX` and to `DIR_RX` on `REQ_RX`; `REQ_HOLD` and `REQ_NONE` keep it in `DIR_OFF`. From `DIR_TX` or `DIR_RX`, a request for the same direction or `REQ_HOLD` keeps the state. A request for the opposite direction, or `REQ_NONE`, returns the machine to `DIR_OFF`. A reversal therefore always passes through one idle cycle.

On transmit, a mode input selects the data source. In one setting the local data passes straight through to the backplane. In the other, the backplane is driven from a register that samples the local data and parity on every rising clock edge.

Top module: `bus_xcvr_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the machine is in `DIR_OFF`. In that state all pull-low enables and all local enables are 0, and `frame_o` is 1. The sample register clears to zero during reset.
- R2: With `pwr_up_i`=1, `tx_en_i`=1 and `rx_en_i`=0, the machine moves from `DIR_OFF` to `DIR_TX` at the next edge. With `rx_en_i`=1 and `tx_en_i`=0, it moves from `DIR_OFF` to `DIR_RX` at the next edge.
- R3: A request for the opposite direction moves `DIR_TX` or `DIR_RX` to `DIR_OFF` for at least one cycle before the new direction is entered.
- R4: With both enables high, the machine keeps `DIR_TX` or `DIR_RX`, and stays in `DIR_OFF` if it is already there. With both enables low, it goes to `DIR_OFF`.
- R5: In `DIR_TX` with `reg_mode_i`=0 and `bp_oe_n_i`=0, `b_pull_o[i]` = NOT `a_data_i[i]`, combinationally.
- R6: In `DIR_TX` with `reg_mode_i`=1 and `bp_oe_n_i`=0, `b_pull_o[i]` = NOT (the `a_data_i[i]` sampled at the previous rising edge).
- R7: `bp_oe_n_i`=1 forces every pull-low enable (data and auxiliary) to 0.
- R8: `pwr_up_i`=0 forces every pull-low enable to 0 in the same cycle. At the next edge the machine goes to `DIR_OFF`.
- R9: In `DIR_RX`, `a_data_oe_o[3:0]` are 1 when `grp1_oe_n_i`=0, and `a_data_oe_o[7:4]` are 1 when `grp2_oe_n_i`=0. `aux_a_oe_o[0]` follows group 1 and `aux_a_oe_o[1]` follows group 2. `a_data_o` equals `b_data_i` and `aux_a_o` equals `aux_b_i`.
- R10: `slave_i`=1 forces `aux_b_pull_o` to 0. With `slave_i`=0 in `DIR_TX` and `bp_oe_n_i`=0, `aux_b_pull_o[k]` = NOT (the lane-k source).
- R11: The source of auxiliary lane 0 is `aux_a_i[0]`. The source of lane 1 is `aux_a_i[1]` when `reg_mode_i`=0, and the `parity_i` value sampled at the previous edge when `reg_mode_i`=1.
- R12: In `DIR_RX` with `lclk_dir_i`=0, `lclk_oe_o`=1 and `lclk_o` = `aux_b_i[0]`. Otherwise `lclk_oe_o`=0.
- R13: `frame_o` = `aux_b_i[1]` in `DIR_RX`, and 1 in any other state.
- R14: No cycle has both a local output enable and a backplane pull-low enable active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; samples data in registered mode |
| rst | input | 1 | Synchronous reset, active high |
| pwr_up_i | input | 1 | Low while power ramps; blocks all transmitters |
| tx_en_i | input | 1 | Transmit request, active high |
| rx_en_i | input | 1 | Receive request, active high |
| reg_mode_i | input | 1 | 0 pass-through, 1 registered transmit |
| bp_oe_n_i | input | 1 | Backplane driver enable, active low |
| grp1_oe_n_i | input | 1 | Local enable for lanes 0-3 and aux lane 0, active low |
| grp2_oe_n_i | input | 1 | Local enable for lanes 4-7 and aux lane 1, active low |
| slave_i | input | 1 | 1 = slave, auxiliary transmitters off |
| lclk_dir_i | input | 1 | 1 = local clock pin is input, 0 = output |
| a_data_i | input | 8 | Local data in |
| a_data_o | output | 8 | Local data out |
| a_data_oe_o | output | 8 | Local data output enables |
| b_data_i | input | 8 | Backplane data as read |
| b_data_pull_o | output | 8 | Backplane data pull-low enables |
| aux_a_i | input | 2 | Local auxiliary lanes in |
| aux_a_o | output | 2 | Local auxiliary lanes out |
| aux_a_oe_o | output | 2 | Local auxiliary output enables |
| aux_b_i | input | 2 | Backplane auxiliary lanes as read |
| aux_b_pull_o | output | 2 | Backplane auxiliary pull-low enables |
| parity_i | input | 1 | Parity bit for auxiliary lane 1 |
| frame_o | output | 1 | Frame pulse received from auxiliary lane 1 |
| lclk_o | output | 1 | Local clock pin output value |
| lclk_oe_o | output | 1 | Local clock pin output enable |

## Verification
The hardest condition to reach is a direct reversal: a receive request arriving in the cycle right after a transmit has been granted. Enable conflicts can only appear at that moment. The stimulus table deliberately flips `tx_en_i` and `rx_en_i` between neighbouring rows, and holds both high across a granted direction. Registered transmit is checked by switching `reg_mode_i` on while the local data changes. The pull-low pattern must then follow the previous cycle's data, not the present data.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        DIR_OFF = 2'd0,
        DIR_TX  = 2'd1,
        DIR_RX  = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_TX   = 2'd1,
        REQ_RX   = 2'd2,
        REQ_HOLD = 2'd3
    } dir_req_e;
endpackage

// File: rtl/xcvr_dir_fsm.sv
module xcvr_dir_fsm
    import xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_up,
    input  logic       tx_en,
    input  logic       rx_en,
    output dir_state_e state_o
);
    dir_state_e state_q;
    dir_state_e state_d;
    dir_req_e   req;

    // Request decode: power-down wins, a double request holds the direction (R4)
    always_comb begin
        if (!pwr_up)            req = REQ_NONE;
        else if (tx_en && rx_en) req = REQ_HOLD;
        else if (tx_en)          req = REQ_TX;
        else if (rx_en)          req = REQ_RX;
        else                     req = REQ_NONE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIR_OFF: begin
                if (req == REQ_TX)      state_d = DIR_TX;
                else if (req == REQ_RX) state_d = DIR_RX;
                else                    state_d = DIR_OFF;
            end
            DIR_TX: begin
                if (req == REQ_TX || req == REQ_HOLD) state_d = DIR_TX;
                else                                  state_d = DIR_OFF;
            end
            DIR_RX: begin
                if (req == REQ_RX || req == REQ_HOLD) state_d = DIR_RX;
                else                                  state_d = DIR_OFF;
            end
            default: state_d = DIR_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DIR_OFF;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route #(
    parameter int GRP_W = 4,
    parameter int N_GRP = 2
) (
    input  logic                   tx_act,
    input  logic                   rx_act,
    input  logic                   reg_mode,
    input  logic                   bp_oe_n,
    input  logic [N_GRP-1:0]       grp_oe_n,
    input  logic                   slave,
    input  logic                   lclk_dir,
    input  logic [GRP_W*N_GRP-1:0] a_data,
    input  logic [GRP_W*N_GRP-1:0] cap_data,
    input  logic                   cap_par,
    input  logic [GRP_W*N_GRP-1:0] b_data,
    input  logic [1:0]             aux_a,
    input  logic [1:0]             aux_b,
    output logic [GRP_W*N_GRP-1:0] a_out,
    output logic [GRP_W*N_GRP-1:0] a_oe,
    output logic [GRP_W*N_GRP-1:0] b_pull,
    output logic [1:0]             aux_a_out,
    output logic [1:0]             aux_a_oe,
    output logic [1:0]             aux_pull,
    output logic                   frame,
    output logic                   lclk,
    output logic                   lclk_oe
);
    localparam int DW = GRP_W * N_GRP;

    logic          drive_ok;
    logic          aux_ok;
    logic [DW-1:0] tx_src;
    logic [1:0]    aux_src;
    logic [N_GRP-1:0] grp_on;

    assign drive_ok = tx_act & ~bp_oe_n;
    assign aux_ok   = drive_ok & ~slave;
    assign tx_src   = reg_mode ? cap_data : a_data;
    assign aux_src  = {(reg_mode ? cap_par : aux_a[1]), aux_a[0]};

    // Open-drain: pull low where the source bit is zero
    assign b_pull   = drive_ok ? ~tx_src : '0;
    assign aux_pull = aux_ok ? ~aux_src : 2'b00;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_on[g] = rx_act & ~grp_oe_n[g];
        assign a_oe[g*GRP_W +: GRP_W] = {GRP_W{grp_on[g]}};
    end

    assign a_out     = b_data;
    assign aux_a_out = aux_b;
    assign aux_a_oe  = {grp_on[N_GRP-1], grp_on[0]};
    assign frame     = rx_act ? aux_b[1] : 1'b1;
    assign lclk      = aux_b[0];
    assign lclk_oe   = rx_act & ~lclk_dir;
endmodule

// File: rtl/bus_xcvr_ctrl.sv
module bus_xcvr_ctrl
    import xcvr_pkg::*;
#(
    parameter int GRP_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_up_i,
    input  logic               tx_en_i,
    input  logic               rx_en_i,
    input  logic               reg_mode_i,
    input  logic               bp_oe_n_i,
    input  logic               grp1_oe_n_i,
    input  logic               grp2_oe_n_i,
    input  logic               slave_i,
    input  logic               lclk_dir_i,
    input  logic [2*GRP_W-1:0] a_data_i,
    output logic [2*GRP_W-1:0] a_data_o,
    output logic [2*GRP_W-1:0] a_data_oe_o,
    input  logic [2*GRP_W-1:0] b_data_i,
    output logic [2*GRP_W-1:0] b_data_pull_o,
    input  logic [1:0]         aux_a_i,
    output logic [1:0]         aux_a_o,
    output logic [1:0]         aux_a_oe_o,
    input  logic [1:0]         aux_b_i,
    output logic [1:0]         aux_b_pull_o,
    input  logic               parity_i,
    output logic               frame_o,
    output logic               lclk_o,
    output logic               lclk_oe_o
);
    localparam int N_GRP = 2;
    localparam int DW    = GRP_W * N_GRP;

    dir_state_e dir_state;
    logic [DW:0] cap_q;
    logic        tx_act;
    logic        rx_act;

    xcvr_dir_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pwr_up  (pwr_up_i),
        .tx_en   (tx_en_i),
        .rx_en   (rx_en_i),
        .state_o (dir_state)
    );

    xcvr_capture #(.WIDTH(DW + 1)) u_cap (
        .clk (clk),
        .rst (rst),
        .d   ({parity_i, a_data_i}),
        .q   (cap_q)
    );

    // Power-up low blocks transmitters at once, not only after the state drops
    assign tx_act = (dir_state == DIR_TX) & pwr_up_i;
    assign rx_act = (dir_state == DIR_RX);

    xcvr_route #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_route (
        .tx_act    (tx_act),
        .rx_act    (rx_act),
        .reg_mode  (reg_mode_i),
        .bp_oe_n   (bp_oe_n_i),
        .grp_oe_n  ({grp2_oe_n_i, grp1_oe_n_i}),
        .slave     (slave_i),
        .lclk_dir  (lclk_dir_i),
        .a_data    (a_data_i),
        .cap_data  (cap_q[DW-1:0]),
        .cap_par   (cap_q[DW]),
        .b_data    (b_data_i),
        .aux_a     (aux_a_i),
        .aux_b     (aux_b_i),
        .a_out     (a_data_o),
        .a_oe      (a_data_oe_o),
        .b_pull    (b_data_pull_o),
        .aux_a_out (aux_a_o),
        .aux_a_oe  (aux_a_oe_o),
        .aux_pull  (aux_b_pull_o),
        .frame     (frame_o),
        .lclk      (lclk_o),
        .lclk_oe   (lclk_oe_o)
    );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker
    import xcvr_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          pwr_up_i,
    input logic          tx_en_i,
    input logic          rx_en_i,
    input logic          reg_mode_i,
    input logic          bp_oe_n_i,
    input logic          slave_i,
    input logic [DW-1:0] a_data_i,
    input logic [DW-1:0] a_data_oe_o,
    input logic [DW-1:0] b_data_pull_o,
    input logic [1:0]    aux_a_oe_o,
    input logic [1:0]    aux_b_pull_o,
    input logic          lclk_oe_o,
    input dir_state_e    state
);
    a_r2_enter_tx: assert property (@(posedge clk) disable iff (rst)
        (state == DIR_OFF && pwr_up_i && tx_en_i && !rx_en_i) |=> state == DIR_TX);

    a_r3_reverse_via_off: assert property (@(posedge clk) disable iff (rst)
        (state == DIR_TX && rx_en_i && !tx_en_i) |=> state == DIR_OFF);

    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (|a_data_oe_o || |aux_a_oe_o) |-> ($past(b_data_pull_o) == '0 && $past(aux_b_pull_o) == 2'b00));

    a_r6_registered: assert property (@(posedge clk) disable iff (rst)
        (state == DIR_TX && pwr_up_i && !bp_oe_n_i && reg_mode_i && !$past(rst))
        |-> b_data_pull_o == ~$past(a_data_i));

    a_r7_bp_disabled: assert property (@(posedge clk) disable iff (rst)
        bp_oe_n_i |-> (b_data_pull_o == '0 && aux_b_pull_o == 2'b00));

    a_r8_power_block: assert property (@(posedge clk) disable iff (rst)
        !pwr_up_i |-> (b_data_pull_o == '0 && aux_b_pull_o == 2'b00));

    a_r10_slave_quiet: assert property (@(posedge clk) disable iff (rst)
        slave_i |-> aux_b_pull_o == 2'b00);

    a_r14_no_conflict: assert property (@(posedge clk) disable iff (rst)
        (|a_data_oe_o || |aux_a_oe_o || lclk_oe_o) |-> (b_data_pull_o == '0 && aux_b_pull_o == 2'b00));
endmodule

bind bus_xcvr_ctrl xcvr_checker #(.DW(2*GRP_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pwr_up_i      (pwr_up_i),
    .tx_en_i       (tx_en_i),
    .rx_en_i       (rx_en_i),
    .reg_mode_i    (reg_mode_i),
    .bp_oe_n_i     (bp_oe_n_i),
    .slave_i       (slave_i),
    .a_data_i      (a_data_i),
    .a_data_oe_o   (a_data_oe_o),
    .b_data_pull_o (b_data_pull_o),
    .aux_a_oe_o    (aux_a_oe_o),
    .aux_b_pull_o  (aux_b_pull_o),
    .lclk_oe_o     (lclk_oe_o),
    .state         (dir_state)
);

// File: tb/tb_bus_xcvr_ctrl.sv
`timescale 1ns/1ps
module tb_bus_xcvr_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_up_i, tx_en_i, rx_en_i, reg_mode_i, bp_oe_n_i;
    logic grp1_oe_n_i, grp2_oe_n_i, slave_i, lclk_dir_i, parity_i;
    logic [7:0] a_data_i, a_data_o, a_data_oe_o, b_data_i, b_data_pull_o;
    logic [1:0] aux_a_i, aux_a_o, aux_a_oe_o, aux_b_i, aux_b_pull_o;
    logic frame_o, lclk_o, lclk_oe_o;

    int n_run = 0;
    int n_fail = 0;
    int ms = 0;          // reference direction: 0 off, 1 transmit, 2 receive
    logic [8:0] mcap = '0;

    always #4 clk = ~clk;

    bus_xcvr_ctrl dut (.*);

    // ctrl bits: pwr,tx,rx,mode,bp_oe_n,g1_n,g2_n,slave,dir | a | b | aux_a | aux_b | par
    localparam int NV = 16;
    localparam logic [29:0] VEC [NV] = '{
        {9'b1_1_0_0_0_1_1_0_1, 8'hA5, 8'h3C, 2'b10, 2'b01, 1'b1},
        {9'b1_1_0_0_0_1_1_0_1, 8'h5A, 8'h3C, 2'b01, 2'b01, 1'b1},
        {9'b1_1_0_1_0_1_1_0_1, 8'hF0, 8'h00, 2'b11, 2'b00, 1'b0},
        {9'b1_1_0_1_0_1_1_1_1, 8'h0F, 8'h00, 2'b00, 2'b00, 1'b1},
        {9'b1_1_0_0_1_1_1_0_1, 8'h00, 8'hFF, 2'b00, 2'b11, 1'b0},
        {9'b1_1_1_0_0_0_0_0_0, 8'h33, 8'h81, 2'b10, 2'b10, 1'b0},
        {9'b1_0_1_0_0_0_0_0_0, 8'hCC, 8'h81, 2'b01, 2'b10, 1'b1},
        {9'b1_0_1_0_0_0_1_0_0, 8'h00, 8'hC3, 2'b00, 2'b10, 1'b0},
        {9'b1_0_1_1_0_1_0_0_1, 8'hFF, 8'h96, 2'b11, 2'b01, 1'b1},
        {9'b1_1_1_0_0_0_0_0_0, 8'h12, 8'h69, 2'b00, 2'b11, 1'b0},
        {9'b1_1_0_0_0_0_0_0_0, 8'h34, 8'h69, 2'b01, 2'b00, 1'b0},
        {9'b1_1_0_0_0_1_1_0_1, 8'h56, 8'h00, 2'b10, 2'b00, 1'b1},
        {9'b0_1_0_0_0_1_1_0_1, 8'h00, 8'h00, 2'b00, 2'b00, 1'b0},
        {9'b1_1_0_0_0_1_1_0_1, 8'h78, 8'h00, 2'b01, 2'b00, 1'b1},
        {9'b1_0_0_1_0_1_1_0_1, 8'h9A, 8'h55, 2'b10, 2'b01, 1'b0},
        {9'b1_0_1_1_0_0_0_0_0, 8'hBC, 8'hAA, 2'b11, 2'b10, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [29:0] v);
        {pwr_up_i, tx_en_i, rx_en_i, reg_mode_i, bp_oe_n_i,
         grp1_oe_n_i, grp2_oe_n_i, slave_i, lclk_dir_i} = v[29:21];
        a_data_i = v[20:13];
        b_data_i = v[12:5];
        aux_a_i  = v[4:3];
        aux_b_i  = v[2:1];
        parity_i = v[0];
    endtask

    // Compare every output against the reference built from the requirements
    task automatic check_model();
        logic tx, rx, aen, psrc;
        logic [7:0] src, epull, eoe;
        logic [1:0] eaux;
        tx   = (ms == 1) && pwr_up_i;
        rx   = (ms == 2);
        src  = reg_mode_i ? mcap[7:0] : a_data_i;
        psrc = reg_mode_i ? mcap[8] : aux_a_i[1];
        epull = (tx && !bp_oe_n_i) ? ~src : 8'h00;
        aen  = tx && !bp_oe_n_i && !slave_i;
        eaux = aen ? {~psrc, ~aux_a_i[0]} : 2'b00;
        eoe  = {{4{rx && !grp2_oe_n_i}}, {4{rx && !grp1_oe_n_i}}};
        chk("R5/R6/R7/R8 data pull", 32'(b_data_pull_o), 32'(epull));
        chk("R10/R11 aux pull", 32'(aux_b_pull_o), 32'(eaux));
        chk("R9 data oe", 32'(a_data_oe_o), 32'(eoe));
        chk("R9 data out", 32'(a_data_o), 32'(b_data_i));
        chk("R9 aux oe", 32'(aux_a_oe_o), 32'({rx && !grp2_oe_n_i, rx && !grp1_oe_n_i}));
        chk("R9 aux out", 32'(aux_a_o), 32'(aux_b_i));
        chk("R13 frame", 32'(frame_o), 32'(rx ? aux_b_i[1] : 1'b1));
        chk("R12 lclk oe", 32'(lclk_oe_o), 32'(rx && !lclk_dir_i));
        chk("R12 lclk", 32'(lclk_o), 32'(aux_b_i[0]));
        chk("R14 conflict", 32'((|a_data_oe_o || |aux_a_oe_o || lclk_oe_o) &&
                                (|b_data_pull_o || |aux_b_pull_o)), 32'd0);
    endtask

    // Advance the reference at the clock edge (R2, R3, R4, R8 state rules)
    task automatic advance();
        int req;
        @(posedge clk);
        if (rst) begin
            ms = 0;
            mcap = '0;
        end else begin
            if (!pwr_up_i)                req = 0;
            else if (tx_en_i && rx_en_i)  req = 3;
            else if (tx_en_i)             req = 1;
            else if (rx_en_i)             req = 2;
            else                          req = 0;
            if (req == 0)        ms = 0;
            else if (req == 3)   ms = ms;
            else if (req == ms)  ms = ms;
            else if (ms == 0)    ms = req;
            else                 ms = 0;
            mcap = {parity_i, a_data_i};
        end
    endtask

    task automatic apply(input logic [29:0] v);
        @(negedge clk);
        drive(v);
        #1;
        check_model();
    endtask

    initial begin
        drive({9'b1_1_0_1_0_0_0_0_0, 8'hFF, 8'h00, 2'b00, 2'b00, 1'b0});
        advance();
        advance();
        // R1: reset holds everything quiet even with transmit requested
        @(negedge clk);
        #1;
        chk("R1 pull in reset", 32'(b_data_pull_o), 32'd0);
        chk("R1 oe in reset", 32'(a_data_oe_o), 32'd0);
        chk("R1 frame in reset", 32'(frame_o), 32'd1);
        rst = 1'b0;
        #1;
        chk("R1 pull after release", 32'(b_data_pull_o), 32'd0);
        advance();

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            advance();
        end

        // Directed: registered latency and turnaround
        apply({9'b0_0_0_0_0_0_0_0_1, 8'h00, 8'h00, 2'b00, 2'b00, 1'b0});
        advance();
        apply({9'b1_1_0_0_0_0_0_0_1, 8'hFF, 8'h00, 2'b00, 2'b00, 1'b0});
        chk("R2 still off before edge", 32'(b_data_pull_o), 32'd0);
        advance();
        apply({9'b1_1_0_1_0_0_0_0_1, 8'h00, 8'h00, 2'b00, 2'b00, 1'b1});
        chk("R6 uses previous sample", 32'(b_data_pull_o), 32'h00);
        chk("R11 parity lane from sample", 32'(aux_b_pull_o), 32'b11);
        advance();
        apply({9'b1_1_0_0_0_0_0_0_1, 8'h00, 8'h00, 2'b00, 2'b00, 1'b0});
        chk("R5 pass-through", 32'(b_data_pull_o), 32'hFF);
        advance();
        apply({9'b1_0_1_0_0_0_0_0_1, 8'h00, 8'h00, 2'b00, 2'b00, 1'b0});
        chk("R3 still transmitting", 32'(b_data_pull_o), 32'hFF);
        advance();
        apply({9'b1_0_1_0_0_0_0_0_1, 8'h00, 8'h00, 2'b00, 2'b00, 1'b0});
        chk("R3 idle cycle pull", 32'(b_data_pull_o), 32'd0);
        chk("R3 idle cycle oe", 32'(a_data_oe_o), 32'd0);
        advance();
        apply({9'b1_1_1_0_0_0_0_0_1, 8'h00, 8'h00, 2'b00, 2'b00, 1'b0});
        chk("R2 receive granted", 32'(a_data_oe_o), 32'hFF);
        advance();
        apply({9'b0_1_0_0_0_0_0_0_1, 8'h00, 8'h00, 2'b00, 2'b00, 1'b0});
        chk("R4 both held receive", 32'(a_data_oe_o), 32'hFF);
        advance();
        apply({9'b0_1_0_0_0_0_0_0_1, 8'h00, 8'h00, 2'b00, 2'b00, 1'b0});
        chk("R8 power low drops to off", 32'(a_data_oe_o), 32'd0);
        chk("R8 no pull", 32'(b_data_pull_o), 32'd0);
        advance();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule